// File: doc/BRIEF.md
# Transmit DMA FIFO Drain Sequencer

This block sits in the data path of a memory-to-peripheral DMA channel. Words read from memory are placed in a small FIFO, and the peripheral takes them from a valid/ready stream. A sequencer walks a chain of descriptors. Each descriptor gives a word count and three flags: a sync flag, an interrupt enable and a final marker. At the end of each descriptor the sync flag selects how the block moves to the next one.

In a synchronized transition the sequencer stops reading memory. It waits until the peripheral has taken every word still in the FIFO. Only then does it raise the interrupt and request the next descriptor. Because the FIFO is always empty at that boundary, the next descriptor is free to use a different element size or direction. In a continuous transition the next descriptor is requested at once, while the FIFO keeps draining in the background. A final descriptor always drains before the channel stops running. Dropping the channel enable at any time discards the FIFO contents.

The descriptor fetch and the memory read port are simple request/acknowledge handshakes. The sequencer has five states:
- IDLE: waiting for the enable.
- FETCH: descriptor request held high.
- MOVE: memory words requested.
- DRAIN: waiting for the FIFO to empty.
- DONE: chain finished, waiting for the enable to drop.

Its transitions are:
- IDLE→FETCH when the enable is high.
- FETCH→MOVE on the descriptor acknowledge.
- MOVE→FETCH on the last word of a continuous, non-final descriptor.
- MOVE→DRAIN on the last word of a synchronized or final descriptor.
- DRAIN→FETCH when the FIFO is empty and the descriptor is not final.
- DRAIN→DONE when the FIFO is empty and the descriptor is final.
- Any state→IDLE when the enable is low.

Top module: `txd_drain_seq`

## Requirements
- R1: While reset is applied and after its release with the enable low, `run`, `irq`, `desc_req`, `rd_req` and `per_valid` are all 0.
- R2: A descriptor moves exactly `desc_words_m1`+1 words (field sampled with `desc_ack`), and the peripheral receives every word read from memory, unchanged and in read order.
- R3: After a synchronized, non-final descriptor, `desc_req` stays low until the FIFO is empty. `desc_req` rises two cycles after the cycle in which the peripheral accepts the last buffered word. In that same cycle `per_valid` is 0, and `irq` equals the descriptor's interrupt enable.
- R4: After a continuous (sync flag 0), non-final descriptor, `desc_req` is high in the cycle after the last word's memory handshake, whether or not the FIFO is empty. `irq` in that cycle equals the descriptor's interrupt enable.
- R5: For a final descriptor (final marker 1), whatever its sync flag, the block drains the FIFO. Two cycles after the peripheral accepts the last word, `run` is 0 and `per_valid` is 0, and `irq` equals the interrupt enable.
- R6: `irq` is a one-cycle pulse. It appears only in the cycles named in R3, R4 and R5, and only when the interrupt enable of the descriptor that finished was 1.
- R7: When `chan_en` is low at a clock edge, in the next cycle `per_valid` and `run` are 0. Buffered words are discarded and never reach the peripheral.
- R8: While the FIFO holds DEPTH words, `rd_req` is 0.
- R9: After a final descriptor completes, `run` and `desc_req` stay 0 while `chan_en` is held high. A new chain starts only after `chan_en` has been low for at least one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low flushes and idles |
| desc_req | output | 1 | Next-descriptor request |
| desc_ack | input | 1 | Descriptor delivered, fields valid |
| desc_words_m1 | input | LW | Descriptor word count minus one |
| desc_sync | input | 1 | 1: synchronized transition after this descriptor |
| desc_irq_en | input | 1 | 1: pulse `irq` when this descriptor finishes |
| desc_last | input | 1 | 1: final descriptor of the chain |
| rd_req | output | 1 | Memory word request |
| rd_ack | input | 1 | Memory word returned on `rd_data` |
| rd_data | input | DW | Memory read data |
| per_valid | output | 1 | Word available to the peripheral |
| per_ready | input | 1 | Peripheral accepts the word |
| per_data | output | DW | Word to the peripheral |
| run | output | 1 | Channel running (FETCH, MOVE or DRAIN) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Chains are run with three patterns:
- All transitions synchronized.
- All transitions continuous.
- Sync flags chosen at random for each descriptor.

Comparing the first two shows whether the fetch request waits for the drain (R3) or rises right after the last memory handshake (R4). A chain run against a peripheral that almost never accepts keeps the FIFO full, which shows whether reads are held back (R8). A chain stopped midway by dropping the enable, and then restarted, shows whether the discarded words can reappear in the data stream (R7, R2). Random acknowledge and ready rates move the drain length and the interrupt cycle around, to catch timing that is off by one.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_MOVE  = 3'd2,
        S_DRAIN = 3'd3,
        S_DONE  = 3'd4
    } txd_state_e;

    typedef struct packed {
        logic sync;
        logic irq_en;
        logic last;
    } txd_flags_t;

endpackage

// File: rtl/txd_fifo.sv
module txd_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wp;
    logic [AW:0]   rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rp[AW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

endmodule

// File: rtl/txd_beat_cnt.sv
module txd_beat_cnt #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [LW-1:0] words_m1,
    output logic          last_beat
);
    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    assign last_beat = (cnt == words_m1);

endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          desc_ack,
    input  txd_flags_t    desc_flags,
    input  logic [LW-1:0] desc_words_m1,
    input  logic          beat,
    input  logic          last_beat,
    input  logic          fifo_empty,
    input  logic          fifo_full,
    output logic          desc_req,
    output logic          rd_req,
    output logic          run,
    output logic          irq,
    output logic          cnt_clr,
    output txd_flags_t    cur_flags,
    output logic [LW-1:0] cur_words_m1
);
    txd_state_e st, nxt;
    logic       end_move;
    logic       end_drain;
    logic       irq_set;

    assign end_move  = (st == S_MOVE) && beat && last_beat;
    assign end_drain = (st == S_DRAIN) && fifo_empty;
    assign irq_set   = chan_en && cur_flags.irq_en &&
                       ((end_move && !cur_flags.sync && !cur_flags.last) || end_drain);

    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (chan_en) nxt = S_FETCH;
            S_FETCH: if (desc_ack) nxt = S_MOVE;
            S_MOVE:  if (end_move)
                         nxt = (cur_flags.sync || cur_flags.last) ? S_DRAIN : S_FETCH;
            S_DRAIN: if (fifo_empty)
                         nxt = cur_flags.last ? S_DONE : S_FETCH;
            S_DONE:  nxt = S_DONE;
        endcase
        if (!chan_en) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st           <= S_IDLE;
            irq          <= 1'b0;
            cur_flags    <= '0;
            cur_words_m1 <= '0;
        end else begin
            st  <= nxt;
            irq <= irq_set;
            if (st == S_FETCH && desc_ack && chan_en) begin
                cur_flags    <= desc_flags;
                cur_words_m1 <= desc_words_m1;
            end
        end
    end

    always_comb begin
        desc_req = 1'b0;
        rd_req   = 1'b0;
        run      = 1'b0;
        cnt_clr  = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_FETCH: begin
                desc_req = chan_en;
                run      = 1'b1;
                cnt_clr  = 1'b1;
            end
            S_MOVE: begin
                rd_req = chan_en && !fifo_full;
                run    = 1'b1;
            end
            S_DRAIN: run = 1'b1;
            S_DONE:  ;
        endcase
    end

endmodule

// File: rtl/txd_drain_seq.sv
module txd_drain_seq
    import txd_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    output logic          desc_req,
    input  logic          desc_ack,
    input  logic [LW-1:0] desc_words_m1,
    input  logic          desc_sync,
    input  logic          desc_irq_en,
    input  logic          desc_last,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          per_valid,
    input  logic          per_ready,
    output logic [DW-1:0] per_data,
    output logic          run,
    output logic          irq
);
    logic          beat;
    logic          pop;
    logic          fifo_full;
    logic          fifo_empty;
    logic          last_beat;
    logic          cnt_clr;
    txd_flags_t    in_flags;
    txd_flags_t    cur_flags;
    logic [LW-1:0] cur_words_m1;
    logic          cur_sync;
    logic          cur_last;

    assign in_flags  = '{sync: desc_sync, irq_en: desc_irq_en, last: desc_last};
    assign beat      = rd_req && rd_ack;
    assign per_valid = chan_en && !fifo_empty;
    assign pop       = per_valid && per_ready;
    assign cur_sync  = cur_flags.sync;
    assign cur_last  = cur_flags.last;

    txd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!chan_en),
        .push  (beat),
        .wdata (rd_data),
        .pop   (pop),
        .rdata (per_data),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    txd_beat_cnt #(.LW(LW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (beat),
        .words_m1  (cur_words_m1),
        .last_beat (last_beat)
    );

    txd_seq #(.LW(LW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_en       (chan_en),
        .desc_ack      (desc_ack),
        .desc_flags    (in_flags),
        .desc_words_m1 (desc_words_m1),
        .beat          (beat),
        .last_beat     (last_beat),
        .fifo_empty    (fifo_empty),
        .fifo_full     (fifo_full),
        .desc_req      (desc_req),
        .rd_req        (rd_req),
        .run           (run),
        .irq           (irq),
        .cnt_clr       (cnt_clr),
        .cur_flags     (cur_flags),
        .cur_words_m1  (cur_words_m1)
    );

endmodule

// File: rtl/txd_chk.sv
module txd_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic irq,
    input logic run,
    input logic desc_req,
    input logic rd_req,
    input logic rd_ack,
    input logic per_valid,
    input logic fifo_empty,
    input logic fifo_full,
    input logic cur_sync,
    input logic cur_last
);
    // R3: a fetch that follows a synchronized descriptor sees an empty FIFO
    a_r3_fetch_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && cur_sync) |-> fifo_empty);

    // R3: a synchronized interrupt sees an empty FIFO
    a_r3_irq_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cur_sync) |-> fifo_empty);

    // R5: the final interrupt comes with the channel stopped and drained
    a_r5_final_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cur_last) |-> (!run && fifo_empty));

    // R6: the interrupt lasts one cycle
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: a low enable flushes and stops the channel
    a_r7_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!per_valid && !run));

    // R8: no word is written into a full FIFO
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !(rd_req && rd_ack));

endmodule

bind txd_drain_seq txd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .irq        (irq),
    .run        (run),
    .desc_req   (desc_req),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .per_valid  (per_valid),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .cur_sync   (cur_sync),
    .cur_last   (cur_last)
);

// File: tb/sim_txd_drain_seq.sv
`timescale 1ns/1ps
module sim_txd_drain_seq;
    localparam int DW    = 16;
    localparam int DEPTH = 8;
    localparam int LW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chan_en = 1'b0;
    logic          desc_req;
    logic          desc_ack = 1'b0;
    logic [LW-1:0] desc_words_m1 = '0;
    logic          desc_sync = 1'b0;
    logic          desc_irq_en = 1'b0;
    logic          desc_last = 1'b0;
    logic          rd_req;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          per_valid;
    logic          per_ready = 1'b0;
    logic [DW-1:0] per_data;
    logic          run;
    logic          irq;

    always #5 clk = ~clk;

    txd_drain_seq #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u0 (.*);

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // bench model
    logic [DW-1:0] q[$];
    logic [DW-1:0] next_val = 16'h1000;
    int  beats_left;
    int  chain_idx;
    int  exp_cyc;
    int  exp_kind;     // 0 continuous, 1 sync non-final, 2 final
    bit  draining;
    bit  finished;
    bit  c_sync, c_irq, c_last;

    function automatic int words_of(input logic [LW-1:0] m1);
        return int'(m1) + 1;
    endfunction

    function automatic bit exp_irq(input bit en);
        return en;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic observe();
        if (cyc == exp_cyc) begin
            chk(irq == exp_irq(c_irq), "R6 irq at end of descriptor", irq, c_irq);
            if (exp_kind == 0) begin
                chk(desc_req == 1'b1, "R4 continuous fetch", desc_req, 1);
            end else if (exp_kind == 1) begin
                chk(desc_req == 1'b1, "R3 sync fetch after drain", desc_req, 1);
                chk(per_valid == 1'b0, "R3 FIFO empty at sync boundary", per_valid, 0);
            end else begin
                chk(run == 1'b0, "R5 run low after final drain", run, 0);
                chk(per_valid == 1'b0, "R5 FIFO empty at final irq", per_valid, 0);
                finished = 1'b1;
            end
        end else if (irq) begin
            chk(1'b0, "R6 unexpected irq", irq, 0);
        end
        if (draining && desc_req) chk(1'b0, "R3 fetch during drain", desc_req, 0);
        if (q.size() == DEPTH) chk(rd_req == 1'b0, "R8 read held when full", rd_req, 0);
        // handshakes at the coming edge
        if (desc_req && desc_ack) begin
            c_sync = desc_sync;
            c_irq  = desc_irq_en;
            c_last = desc_last;
            beats_left = words_of(desc_words_m1);
            chain_idx++;
        end
        if (per_valid && per_ready) begin
            logic [DW-1:0] e;
            e = (q.size() > 0) ? q.pop_front() : 'x;
            chk(per_data === e, "R2 data order", per_data, e);
            if (draining && q.size() == 0) begin
                draining = 1'b0;
                exp_cyc  = cyc + 2;
                exp_kind = c_last ? 2 : 1;
            end
        end
        if (rd_req && rd_ack) begin
            q.push_back(rd_data);
            next_val++;
            beats_left--;
            if (beats_left == 0) begin
                if (!c_sync && !c_last) begin
                    exp_cyc  = cyc + 1;
                    exp_kind = 0;
                end else begin
                    draining = 1'b1;
                end
            end else if (beats_left < 0) begin
                chk(1'b0, "R2 word count exceeded", beats_left, 0);
            end
        end
    endtask

    // mode: 0 random sync, 1 all sync, 2 all continuous
    task automatic run_chain(input int n_desc, input int mode, input int ack_pct,
                             input int rdy_pct, input int abort_at);
        q.delete();
        beats_left = 0; chain_idx = 0; exp_cyc = -1; exp_kind = 0;
        draining = 1'b0; finished = 1'b0;
        c_sync = 1'b0; c_irq = 1'b0; c_last = 1'b0;
        for (int s = 0; s < 4000; s++) begin
            @(negedge clk);
            cyc++;
            chan_en       = 1'b1;
            desc_ack      = ($urandom % 100) < 60;
            desc_words_m1 = LW'($urandom % 6);
            desc_sync     = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom % 2);
            desc_irq_en   = 1'($urandom % 2);
            desc_last     = (chain_idx == n_desc - 1);
            rd_ack        = ($urandom % 100) < ack_pct;
            per_ready     = ($urandom % 100) < rdy_pct;
            rd_data       = next_val;
            if (s == abort_at) begin
                chan_en = 1'b0;
                @(negedge clk);
                cyc++;
                #1;
                chk(per_valid == 1'b0, "R7 flush on disable", per_valid, 0);
                chk(run == 1'b0, "R7 run low on disable", run, 0);
                return;
            end
            #1;
            observe();
            if (finished) break;
        end
        if (!finished) chk(1'b0, "R5 chain never finished", 0, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cyc++;
            #1;
            chk(!run && !desc_req, "R9 stays done while enabled", run, 0);
        end
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        chk(!run && !irq && !desc_req && !rd_req && !per_valid, "R1 reset outputs", run, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!run && !irq && !desc_req && !rd_req && !per_valid, "R1 idle after reset", desc_req, 0);
        run_chain(1, 2, 70, 70, -1);      // single final continuous descriptor
        run_chain(4, 1, 80, 60, -1);      // all synchronized
        run_chain(5, 2, 80, 60, -1);      // all continuous
        run_chain(3, 0, 90, 5, -1);       // peripheral nearly stalled: FIFO fills
        run_chain(4, 2, 90, 10, 25);      // abort midway (R7)
        run_chain(3, 1, 70, 70, -1);      // restart after abort: old words must not reappear
        for (int r = 0; r < 25; r++)
            run_chain(1 + int'($urandom % 5), 0, 30 + int'($urandom % 70),
                      20 + int'($urandom % 80), -1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule